// File: doc/BRIEF.md
# Space-Time First-Order Directional IIR Filter Array

This block filters the snapshots of a uniform linear antenna array so that plane waves arriving from one steered direction are enhanced and others are attenuated. It is built as a chain of identical cells, one per antenna. On each accepted clock it takes one signed sample per antenna and produces one filtered sample per antenna. Each cell adds three things: its own input, a scaled spatial difference between its left neighbour's stored output and its own, and a scaled copy of its own previous output. Because the spatial coupling uses the difference form, each cell needs only two multipliers. The passband is a line in the space-time frequency plane.

Steering is set by two signed fixed-point coefficients supplied as static inputs. The spatial gain is `alpha_sp`. The temporal feedback gain `beta_tm` is the temporal coefficient minus one. Both are derived offline from the steering angle and the selectivity. All arithmetic rounds and saturates to the data width. The block is meant to sit directly behind a sample-aligned front end that raises a strobe with every snapshot.

Top module: `beam2d_iir_array`

## Requirements
- R1: A synchronous reset high at a clock edge clears `out_valid` to 0 and every output lane to 0 after that edge.
- R2: `out_valid` is `in_valid` delayed by exactly one clock.
- R3: A clock with `in_valid` low leaves every output lane unchanged.
- R4: On a clock with `in_valid` high, each cell k computes its new output from its stored output y[k] and the stored output y[k-1] of cell k-1, in this order:
  - d = y[k-1] - y[k]
  - t1 = S(Q(alpha_sp·d))
  - v = S(w[k] + t1)
  - t2 = S(Q(beta_tm·y[k]))
  - y[k] ← S(t2 + v)
- R5: Cell 0 uses the value 0 in place of the missing left neighbour output.
- R6: S() clamps a value to the range [-2^(DW-1), 2^(DW-1)-1]. Q() adds 2^(FB-1) to the product and then shifts it right arithmetically by FB bits. With FB=14 and CW=16, both coefficients are signed Q2.14.
- R7: With both coefficients zero, every output lane equals the corresponding input lane one clock after a valid input.
- R8: Antenna k occupies bits [k·DW +: DW] of both `in_samp` and `out_samp`, in two's complement.
- R9: When all inputs and all stored outputs are zero, a valid input keeps every output at zero, whatever the coefficients are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe marking a new input snapshot |
| in_samp | input | NUM_ANT*DW | One signed sample per antenna, lane k at bits k*DW |
| alpha_sp | input | CW | Spatial difference coefficient, signed, FB fractional bits |
| beta_tm | input | CW | Temporal feedback coefficient, signed, FB fractional bits |
| out_valid | output | 1 | Strobe marking a new output snapshot |
| out_samp | output | NUM_ANT*DW | One filtered signed sample per antenna |

## Verification
The bench builds the block with its defaults: 32 antennas, 16-bit samples and 16-bit coefficients with 14 fractional bits. This is the array size and word format the filter is specified for. With that coefficient format, gains close to +2 and -2 can be applied to full-scale samples, so every saturation stage can be driven into clipping at both ends. Thirty-two lanes give a long enough chain to see the spatial coupling spread from the edge cell, which has no neighbour, into the interior. A steering pair computed for a 35-degree arrival with selectivity 0.005 exercises the ordinary operating region under random data and random valid gaps.

// File: rtl/beam2d_pkg.sv
package beam2d_pkg;

  // Clamp a wide signed value into a w-bit two's complement range.
  function automatic longint sat_w(input longint x, input int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (x > hi)      return hi;
    else if (x < lo) return lo;
    else             return x;
  endfunction

  // Round half up, then drop fb fractional bits.
  function automatic longint rnd_shr(input longint p, input int fb);
    return (p + (longint'(1) <<< (fb - 1))) >>> fb;
  endfunction

  // Fixed-point multiply: product, rounding, saturation to w bits.
  function automatic longint mul_q(input longint x, input longint c,
                                   input int fb, input int w);
    return sat_w(rnd_shr(x * c, fb), w);
  endfunction

endpackage

// File: rtl/beam2d_vld_pipe.sv
module beam2d_vld_pipe (
  input  logic clk,
  input  logic rst,
  input  logic vld_in,
  output logic vld_out
);
  always_ff @(posedge clk) begin
    if (rst) vld_out <= 1'b0;
    else     vld_out <= vld_in;
  end
endmodule

// File: rtl/beam2d_cell.sv
module beam2d_cell #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int FB = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] w,
  input  logic signed [DW-1:0] nbr,
  input  logic signed [CW-1:0] a1,
  input  logic signed [CW-1:0] bt,
  output logic signed [DW-1:0] y
);
  import beam2d_pkg::*;

  longint d_l, t1_l, v_l, t2_l, yn_l;
  logic signed [DW-1:0] y_d;

  always_comb begin
    d_l  = longint'(nbr) - longint'(y);
    t1_l = mul_q(d_l, longint'(a1), FB, DW);
    v_l  = sat_w(longint'(w) + t1_l, DW);
    t2_l = mul_q(longint'(y), longint'(bt), FB, DW);
    yn_l = sat_w(t2_l + v_l, DW);
    y_d  = yn_l[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     y <= '0;
    else if (en) y <= y_d;
  end
endmodule

// File: rtl/beam2d_iir_array.sv
module beam2d_iir_array #(
  parameter int NUM_ANT = 32,
  parameter int DW      = 16,
  parameter int CW      = 16,
  parameter int FB      = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [NUM_ANT*DW-1:0]   in_samp,
  input  logic signed [CW-1:0]    alpha_sp,
  input  logic signed [CW-1:0]    beta_tm,
  output logic                    out_valid,
  output logic [NUM_ANT*DW-1:0]   out_samp
);
  localparam int VW = NUM_ANT * DW;

  // Update strobe shared by every cell; brought out for the checker.
  logic state_en;
  assign state_en = in_valid;

  logic signed [DW-1:0] y_arr [NUM_ANT];

  for (genvar k = 0; k < NUM_ANT; k++) begin : g_cell
    logic signed [DW-1:0] nbr_w;
    logic signed [DW-1:0] w_k;
    if (k == 0) begin : g_edge
      assign nbr_w = '0;
    end else begin : g_inner
      assign nbr_w = y_arr[k-1];
    end
    assign w_k = in_samp[k*DW +: DW];

    beam2d_cell #(.DW(DW), .CW(CW), .FB(FB)) u_cell (
      .clk (clk),
      .rst (rst),
      .en  (state_en),
      .w   (w_k),
      .nbr (nbr_w),
      .a1  (alpha_sp),
      .bt  (beta_tm),
      .y   (y_arr[k])
    );
    assign out_samp[k*DW +: DW] = y_arr[k];
  end

  beam2d_vld_pipe u_vld (
    .clk     (clk),
    .rst     (rst),
    .vld_in  (in_valid),
    .vld_out (out_valid)
  );

  if (VW < DW) begin : g_bad_cfg
    initial $error("lane vector narrower than one sample");
  end
endmodule

// File: rtl/beam2d_chk.sv
module beam2d_chk #(
  parameter int VW = 512,
  parameter int CW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 state_en,
  input logic [VW-1:0]        in_samp,
  input logic signed [CW-1:0] alpha_sp,
  input logic signed [CW-1:0] beta_tm,
  input logic                 out_valid,
  input logic [VW-1:0]        out_samp
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: outputs are cleared after a reset edge
  always @(negedge clk) begin
    if (rst_d) begin
      a_reset_clear_r1: assert (out_valid == 1'b0 && out_samp == '0)
        else $error("reset did not clear outputs");
    end
  end

  p_vld_rise_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_vld_low_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !state_en |=> $stable(out_samp));

  p_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && alpha_sp == '0 && beta_tm == '0) |=> out_samp == $past(in_samp));

  p_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_samp == '0 && out_samp == '0) |=> out_samp == '0);
endmodule

bind beam2d_iir_array beam2d_chk #(.VW(NUM_ANT*DW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .state_en  (state_en),
  .in_samp   (in_samp),
  .alpha_sp  (alpha_sp),
  .beta_tm   (beta_tm),
  .out_valid (out_valid),
  .out_samp  (out_samp)
);

// File: tb/sim_beam2d_iir_array.sv
module sim_beam2d_iir_array;
  localparam int NA = 32;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int FB = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [NA*DW-1:0] in_samp = '0;
  logic signed [CW-1:0] alpha_sp = '0;
  logic signed [CW-1:0] beta_tm = '0;
  logic out_valid;
  logic [NA*DW-1:0] out_samp;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  longint ref_y [NA];
  longint w_cur [NA];

  always #10 clk = ~clk;

  beam2d_iir_array #(.NUM_ANT(NA), .DW(DW), .CW(CW), .FB(FB)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_samp(in_samp),
    .alpha_sp(alpha_sp), .beta_tm(beta_tm),
    .out_valid(out_valid), .out_samp(out_samp)
  );

  // Independent model arithmetic (real-based rounding, explicit clamp).
  function automatic longint clampv(input longint x);
    longint top;
    top = 0;
    for (int i = 0; i < DW - 1; i++) top = top * 2 + 1;
    if (x > top) return top;
    if (x < -top - 1) return -top - 1;
    return x;
  endfunction

  function automatic longint qround(input longint p);
    real scale;
    scale = 1.0;
    for (int i = 0; i < FB; i++) scale = scale * 2.0;
    return longint'($floor(real'(p) / scale + 0.5));
  endfunction

  task automatic model_step();
    longint nxt [NA];
    longint nb, d, t1, v, t2;
    for (int k = 0; k < NA; k++) begin
      nb = (k == 0) ? 0 : ref_y[k-1];
      d  = nb - ref_y[k];
      t1 = clampv(qround(d * longint'(alpha_sp)));
      v  = clampv(w_cur[k] + t1);
      t2 = clampv(qround(ref_y[k] * longint'(beta_tm)));
      nxt[k] = clampv(t2 + v);
    end
    for (int k = 0; k < NA; k++) ref_y[k] = nxt[k];
  endtask

  task automatic pack_inputs();
    for (int k = 0; k < NA; k++) in_samp[k*DW +: DW] = w_cur[k][DW-1:0];
  endtask

  task automatic check_outputs(input bit exp_vld, input string tag);
    longint got;
    n_chk++;
    if (out_valid !== exp_vld) begin
      n_bad++;
      $display("FAIL R2 out_valid: actual %0b expected %0b", out_valid, exp_vld);
    end
    for (int k = 0; k < NA; k++) begin
      got = longint'($signed(out_samp[k*DW +: DW]));
      n_chk++;
      if (got !== ref_y[k]) begin
        n_bad++;
        $display("FAIL %s lane %0d: actual %0d expected %0d", (k == 0) ? "R5" : tag,
                 k, got, ref_y[k]);
      end
    end
  endtask

  // Drive one clock of stimulus, then check one clock later, away from the edge.
  task automatic step(input bit vld, input string tag);
    @(negedge clk);
    in_valid = vld;
    pack_inputs();
    if (vld) model_step();
    @(posedge clk);
    #1;
    check_outputs(vld, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(posedge clk);
    #1;
    for (int k = 0; k < NA; k++) ref_y[k] = 0;
    check_outputs(1'b0, "R1");
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic rand_inputs(input int amp_bits);
    for (int k = 0; k < NA; k++)
      w_cur[k] = clampv(longint'($signed(DW'($urandom))) >>> (DW - amp_bits));
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240607);
    for (int k = 0; k < NA; k++) begin ref_y[k] = 0; w_cur[k] = 0; end

    // R1: reset state
    repeat (2) @(posedge clk);
    do_reset();

    // R7: zero coefficients pass samples through
    alpha_sp = '0; beta_tm = '0;
    for (int i = 0; i < 10; i++) begin rand_inputs(DW); step(1'b1, "R7"); end

    // R8: single lane impulse lands only in its own slice
    for (int k = 0; k < NA; k++) w_cur[k] = 0;
    w_cur[9] = -12345;
    step(1'b1, "R8");

    // R4 / R2 / R3: steered for 35 degrees, selectivity 0.005 (approx 1.2663 and -0.2736)
    alpha_sp = 16'sd20747; beta_tm = -16'sd4482;
    for (int i = 0; i < 400; i++) begin
      bit v;
      v = ($urandom % 4) != 0;
      rand_inputs((i % 3 == 0) ? DW : 12);
      step(v, v ? "R4" : "R3");
    end

    // R6: drive every saturation stage to both ends
    alpha_sp = 16'sd32767; beta_tm = 16'sd32767;
    for (int k = 0; k < NA; k++) w_cur[k] = 32767;
    for (int i = 0; i < 12; i++) step(1'b1, "R6");
    for (int k = 0; k < NA; k++) w_cur[k] = -32768;
    for (int i = 0; i < 12; i++) step(1'b1, "R6");
    alpha_sp = -16'sd32768; beta_tm = -16'sd32768;
    for (int i = 0; i < 8; i++) begin rand_inputs(DW); step(1'b1, "R6"); end

    // R5: edge cell sees zero while its neighbours carry large values
    do_reset();
    alpha_sp = 16'sd20747; beta_tm = -16'sd4482;
    for (int k = 0; k < NA; k++) w_cur[k] = 30000;
    w_cur[0] = 1000;
    for (int i = 0; i < 6; i++) step(1'b1, "R5");

    // R1 mid-run, then R9 zero stays zero
    do_reset();
    for (int k = 0; k < NA; k++) w_cur[k] = 0;
    for (int i = 0; i < 5; i++) step(1'b1, "R9");
    step(1'b0, "R3");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule